// File: doc/BRIEF.md
# BCD real-time clock with alarm

This block keeps wall-clock time in packed BCD: seconds, minutes and hours, plus a three-bit weekday. A sub-second divider counts system clock cycles and produces a one-cycle second tick every `SUBSEC_DIV` cycles. The hour field uses either a 24-hour encoding or a 12-hour encoding in which bit 5 marks the afternoon. A single control bit selects the encoding. The weekday is a plain counter. Software loads it, and it advances only when the hour rolls past midnight.

An alarm compares minute, hour and a seven-bit weekday mask against the time that each minute rollover produces. A periodic event fires once per second, minute, hour or day, as selected. Each source latches its own flag, and each flag drives an interrupt line. Software clears a flag by writing 0 to its bit. A 1 leaves the bit as it is.

A wait bit stops the time from changing, so software can read or load all fields as one consistent set. At most one second that arrives during the wait is remembered, and it is applied once the wait bit is cleared. Access is through a byte-wide register port with a combinational read path.

Top module: `rtc_calendar`

## Requirements
- R1: After reset, every time field reads 0, the flag register reads 0 and control reads 0x01 (24-hour mode). Offsets: 0 seconds, 1 minutes, 2 hours, 3 weekday (bits 2:0), 4 alarm minute, 5 alarm hour, 6 alarm weekday mask (bit n = weekday n), 7 control, 8 flags. Control bits: 0 = 24-hour mode, 1 = alarm enable, 2 = periodic enable, 5:3 = periodic select, 6 = wait. Flag bits: 0 = periodic, 1 = alarm.
- R2: The seconds field advances once every `SUBSEC_DIV` clock cycles. A write to the seconds register restarts the divider, so the first advance lands on the `SUBSEC_DIV`-th edge after that write. The same write discards any remembered second.
- R3: Seconds and minutes count in BCD from 00 to 59. On wrap each carries into the next field.
- R4: In 24-hour mode the hour counts 00 to 23 in BCD. The wrap from 23 to 00 advances the weekday.
- R5: In 12-hour mode the hours are 01–12 for AM and 21–32 for PM. 0x11 rolls to 0x32, 0x32 to 0x21, 0x12 to 0x01, and 0x31 to 0x12. The last of these advances the weekday.
- R6: The weekday holds the value written, wraps from 6 to 0, and changes only at midnight.
- R7: While wait is 1 no time field changes by counting. One pending second is applied in the cycle after wait returns to 0, however many seconds elapsed during the wait.
- R8: At a minute rollover the alarm flag sets when the alarm is enabled, the new minute and hour equal the alarm registers, and the mask bit of the new weekday is 1.
- R9: An alarm minute outside BCD 00–59, or an alarm hour outside the range of the current mode, never sets the alarm flag.
- R10: With periodic enable set, the periodic flag sets on the event chosen by select: 0 each second, 1 each minute, 2 each hour, 3 each day. Other codes never set it.
- R11: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A set and a clear in the same cycle leave the flag set.
- R12: A write to the periodic select field is ignored while periodic enable is already 1.
- R13: `irq_alarm` and `irq_periodic` follow the alarm and periodic flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_alarm | output | 1 | Alarm flag level |
| irq_periodic | output | 1 | Periodic flag level |

## Verification
The alarm and the periodic minute event both fire on the same minute rollover. A single run from 23:59:59 therefore has to leave both flag bits set. The second collision is between a hardware flag set and a software write of zeros to the flag register. The bench counts cycles from the seconds write so that the clear lands on exactly the edge where the minute rolls over, and it then expects both flags to read as set. A design that let the clear win would read 0 there instead.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam logic [3:0] A_SEC   = 4'd0;
    localparam logic [3:0] A_MIN   = 4'd1;
    localparam logic [3:0] A_HOUR  = 4'd2;
    localparam logic [3:0] A_WDAY  = 4'd3;
    localparam logic [3:0] A_AMIN  = 4'd4;
    localparam logic [3:0] A_AHOUR = 4'd5;
    localparam logic [3:0] A_AMASK = 4'd6;
    localparam logic [3:0] A_CTRL  = 4'd7;
    localparam logic [3:0] A_FLAG  = 4'd8;

    localparam logic [2:0] PS_SEC  = 3'd0;
    localparam logic [2:0] PS_MIN  = 3'd1;
    localparam logic [2:0] PS_HOUR = 3'd2;
    localparam logic [2:0] PS_DAY  = 3'd3;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [2:0] wday;
    } rtc_time_t;

    typedef struct packed {
        logic       wait_b;
        logic [2:0] per_sel;
        logic       per_en;
        logic       alm_en;
        logic       mode24;
    } rtc_ctrl_t;

    typedef struct packed {
        logic sec;
        logic min;
        logic hour;
        logic day;
    } rtc_carry_t;

    // Packed BCD value in 00..59.
    function automatic logic min_ok(input logic [7:0] b);
        return (b[7:4] <= 4'd5) && (b[3:0] <= 4'd9);
    endfunction

    // Hour value legal in the selected encoding.
    function automatic logic hour_ok(input logic [7:0] b, input logic m24);
        logic [4:0] low;
        low = b[4:0];
        if (m24)
            return (b[7:6] == 2'b00) && (b[3:0] <= 4'd9) && (b <= 8'h23);
        return (b[7:6] == 2'b00) && (b[3:0] <= 4'd9) &&
               (low >= 5'h01) && (low <= 5'h12);
    endfunction

    // Base-60 BCD increment: {carry, next}.
    function automatic logic [8:0] inc_base60(input logic [7:0] b);
        if (b[3:0] >= 4'd9) begin
            if (b[7:4] >= 4'd5)
                return {1'b1, 8'h00};
            return {1'b0, b[7:4] + 4'd1, 4'd0};
        end
        return {1'b0, b[7:4], b[3:0] + 4'd1};
    endfunction

    // Hour increment in either encoding: {day_carry, next}.
    function automatic logic [8:0] hour_inc(input logic [7:0] h, input logic m24);
        logic       pm;
        logic [4:0] low;
        pm  = h[5];
        low = h[4:0];
        if (m24) begin
            if (h >= 8'h23)
                return {1'b1, 8'h00};
            if (h[3:0] >= 4'd9)
                return {1'b0, h[7:4] + 4'd1, 4'd0};
            return {1'b0, h[7:4], h[3:0] + 4'd1};
        end
        if (low == 5'h11)
            return {pm, 2'b00, ~pm, 5'h12};
        if (low >= 5'h12)
            return {1'b0, 2'b00, pm, 5'h01};
        if (low[3:0] >= 4'd9)
            return {1'b0, 2'b00, pm, 1'b1, 4'd0};
        return {1'b0, 2'b00, pm, low[4], low[3:0] + 4'd1};
    endfunction

    function automatic logic [2:0] wday_inc(input logic [2:0] w);
        return (w >= 3'd6) ? 3'd0 : w + 3'd1;
    endfunction

endpackage

// File: rtl/rtc_subsec.sv
module rtc_subsec #(
    parameter int DIV = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic clear_i,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear_i)
            cnt_q <= '0;
        else if (tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // R2: the divider restarts after every tick
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt_q == '0));

    // R2: count never leaves its range
    a_r2_range: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       wait_i,
    input  logic       mode24_i,
    input  logic       we_i,
    input  logic [3:0] addr_i,
    input  logic [7:0] wdata_i,
    output rtc_time_t  now_o,
    output rtc_time_t  next_o,
    output rtc_carry_t carry_o
);
    rtc_time_t  cur_q;
    rtc_time_t  nxt;
    rtc_carry_t cy;
    logic       pend_q;
    logic       step;
    logic       sec_wr;
    logic [8:0] s_inc;
    logic [8:0] m_inc;
    logic [8:0] h_inc;

    assign sec_wr = we_i && (addr_i == A_SEC);

    always_comb begin
        step  = (tick_i | pend_q) & ~wait_i;
        s_inc = inc_base60(cur_q.sec);
        m_inc = inc_base60(cur_q.min);
        h_inc = hour_inc(cur_q.hour, mode24_i);
        nxt   = cur_q;
        cy    = '0;
        if (step) begin
            cy.sec  = 1'b1;
            nxt.sec = s_inc[7:0];
            if (s_inc[8]) begin
                cy.min  = 1'b1;
                nxt.min = m_inc[7:0];
                if (m_inc[8]) begin
                    cy.hour  = 1'b1;
                    nxt.hour = h_inc[7:0];
                    if (h_inc[8]) begin
                        cy.day   = 1'b1;
                        nxt.wday = wday_inc(cur_q.wday);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            cur_q <= nxt;
            if (we_i) begin
                case (addr_i)
                    A_SEC:   cur_q.sec  <= wdata_i;
                    A_MIN:   cur_q.min  <= wdata_i;
                    A_HOUR:  cur_q.hour <= wdata_i;
                    A_WDAY:  cur_q.wday <= wdata_i[2:0];
                    default: ;
                endcase
            end
            if (sec_wr)
                pend_q <= 1'b0;
            else if (tick_i && wait_i)
                pend_q <= 1'b1;
            else if (step)
                pend_q <= 1'b0;
        end
    end

    assign now_o   = cur_q;
    assign next_o  = nxt;
    assign carry_o = cy;

    // R7: time is frozen while wait is held and nothing is written
    a_r7_wait_freezes: assert property (@(posedge clk) disable iff (rst)
        (wait_i && !we_i) |=> $stable(cur_q));

    // R7: a pending second never survives a cycle without wait
    a_r7_single_pending: assert property (@(posedge clk) disable iff (rst)
        (!wait_i && !sec_wr) |=> !pend_q);

    // R3: counting keeps a legal minute legal
    a_r3_min_range: assert property (@(posedge clk) disable iff (rst)
        (step && !we_i && min_ok(cur_q.min)) |=> min_ok(cur_q.min));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
    import rtc_pkg::*;
(
    input  rtc_time_t  cand_i,
    input  logic [7:0] amin_i,
    input  logic [7:0] ahour_i,
    input  logic [6:0] amask_i,
    input  logic       mode24_i,
    output logic       hit_o
);
    logic       legal;
    logic       same;
    logic [7:0] mask8;
    logic       unused_sec;

    assign unused_sec = ^cand_i.sec;
    assign mask8      = {1'b0, amask_i};

    always_comb begin
        legal = min_ok(amin_i) && hour_ok(ahour_i, mode24_i);
        same  = (cand_i.min == amin_i) && (cand_i.hour == ahour_i);
        hit_o = legal && same && mask8[cand_i.wday];
    end

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int SUBSEC_DIV = 32768
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq_alarm,
    output logic       irq_periodic
);
    localparam rtc_ctrl_t CTRL_RST = '{wait_b: 1'b0, per_sel: 3'd0, per_en: 1'b0,
                                       alm_en: 1'b0, mode24: 1'b1};

    rtc_ctrl_t  ctrl_q;
    logic [7:0] amin_q;
    logic [7:0] ahour_q;
    logic [6:0] amask_q;
    logic [1:0] flag_q;
    logic [1:0] flag_nxt;

    logic       tick;
    logic       sec_wr;
    logic       flag_wr;
    logic       ctrl_wr;
    rtc_time_t  now_t;
    rtc_time_t  next_t;
    rtc_carry_t cy;
    logic       hit;
    logic       per_evt;
    logic       per_set;
    logic       alm_set;

    assign sec_wr  = bus_we && (bus_addr == A_SEC);
    assign flag_wr = bus_we && (bus_addr == A_FLAG);
    assign ctrl_wr = bus_we && (bus_addr == A_CTRL);

    rtc_subsec #(.DIV(SUBSEC_DIV)) i_subsec (
        .clk     (clk),
        .rst     (rst),
        .clear_i (sec_wr),
        .tick_o  (tick)
    );

    rtc_time_core i_core (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick),
        .wait_i   (ctrl_q.wait_b),
        .mode24_i (ctrl_q.mode24),
        .we_i     (bus_we),
        .addr_i   (bus_addr),
        .wdata_i  (bus_wdata),
        .now_o    (now_t),
        .next_o   (next_t),
        .carry_o  (cy)
    );

    rtc_alarm_match i_match (
        .cand_i   (next_t),
        .amin_i   (amin_q),
        .ahour_i  (ahour_q),
        .amask_i  (amask_q),
        .mode24_i (ctrl_q.mode24),
        .hit_o    (hit)
    );

    always_comb begin
        case (ctrl_q.per_sel)
            PS_SEC:  per_evt = cy.sec;
            PS_MIN:  per_evt = cy.min;
            PS_HOUR: per_evt = cy.hour;
            PS_DAY:  per_evt = cy.day;
            default: per_evt = 1'b0;
        endcase
        per_set  = ctrl_q.per_en && per_evt;
        alm_set  = ctrl_q.alm_en && cy.min && hit;
        flag_nxt = (flag_wr ? (flag_q & bus_wdata[1:0]) : flag_q) | {alm_set, per_set};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            amin_q  <= '0;
            ahour_q <= '0;
            amask_q <= '0;
            flag_q  <= '0;
        end else begin
            flag_q <= flag_nxt;
            if (ctrl_wr) begin
                ctrl_q.wait_b <= bus_wdata[6];
                ctrl_q.per_en <= bus_wdata[2];
                ctrl_q.alm_en <= bus_wdata[1];
                ctrl_q.mode24 <= bus_wdata[0];
                if (!ctrl_q.per_en)
                    ctrl_q.per_sel <= bus_wdata[5:3];
            end
            if (bus_we && (bus_addr == A_AMIN))  amin_q  <= bus_wdata;
            if (bus_we && (bus_addr == A_AHOUR)) ahour_q <= bus_wdata;
            if (bus_we && (bus_addr == A_AMASK)) amask_q <= bus_wdata[6:0];
        end
    end

    always_comb begin
        case (bus_addr)
            A_SEC:   bus_rdata = now_t.sec;
            A_MIN:   bus_rdata = now_t.min;
            A_HOUR:  bus_rdata = now_t.hour;
            A_WDAY:  bus_rdata = {5'b0, now_t.wday};
            A_AMIN:  bus_rdata = amin_q;
            A_AHOUR: bus_rdata = ahour_q;
            A_AMASK: bus_rdata = {1'b0, amask_q};
            A_CTRL:  bus_rdata = {1'b0, ctrl_q};
            A_FLAG:  bus_rdata = {6'b0, flag_q};
            default: bus_rdata = 8'h00;
        endcase
    end

    assign irq_alarm    = flag_q[1];
    assign irq_periodic = flag_q[0];

    // R11: a hardware set is never lost to a same-cycle clear
    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        alm_set |=> flag_q[1]);

    // R11: without a set or a write the alarm flag keeps its value
    a_r11_flag_hold: assert property (@(posedge clk) disable iff (rst)
        (!alm_set && !flag_wr) |=> $stable(flag_q[1]));

    // R12: select is frozen while periodic enable is on
    a_r12_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.per_en |=> $stable(ctrl_q.per_sel));

    // R9: an illegal alarm hour blocks the flag
    a_r9_bad_hour: assert property (@(posedge clk) disable iff (rst)
        !hour_ok(ahour_q, ctrl_q.mode24) |-> !alm_set);

endmodule

// File: tb/test_rtc_calendar.sv
module test_rtc_calendar;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 8;

    localparam logic [3:0] A_SEC = 4'd0, A_MIN = 4'd1, A_HOUR = 4'd2, A_WDAY = 4'd3;
    localparam logic [3:0] A_AMIN = 4'd4, A_AHOUR = 4'd5, A_AMASK = 4'd6;
    localparam logic [3:0] A_CTRL = 4'd7, A_FLAG = 4'd8;

    // {mode24, hour, min, sec, seconds to run, exp hour, exp min, exp sec}
    localparam logic [63:0] VECS [8] = '{
        64'h01_12_34_56_01_12_34_57,   // R3 plain second
        64'h01_09_59_59_01_10_00_00,   // R3 R4 BCD digit carry into hour
        64'h01_23_59_58_03_00_00_01,   // R4 midnight wrap
        64'h00_11_59_59_01_32_00_00,   // R5 11 AM to 12 PM
        64'h00_32_59_59_01_21_00_00,   // R5 12 PM to 1 PM
        64'h00_31_59_59_01_12_00_00,   // R5 11 PM to 12 AM
        64'h00_09_59_59_02_10_00_01,   // R5 digit carry in 12-hour
        64'h01_19_29_50_0A_19_30_00    // R2 R3 ten seconds
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] bus_addr;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       irq_alarm;
    logic       irq_periodic;

    int n_vec = 0;
    int n_bad = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_calendar #(.SUBSEC_DIV(DIV)) i_rtc_calendar (
        .clk          (clk),
        .rst          (rst),
        .bus_addr     (bus_addr),
        .bus_we       (bus_we),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .irq_alarm    (irq_alarm),
        .irq_periodic (irq_periodic)
    );

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge; returns at the negedge after.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic rdchk(input string req, input logic [3:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    // Load a time under wait, release, let n seconds elapse, then freeze again.
    task automatic run_secs(input logic [7:0] cb, input logic [7:0] h, input logic [7:0] m,
                            input logic [7:0] s, input int n);
        wr(A_CTRL, cb | 8'h40);
        wr(A_HOUR, h);
        wr(A_MIN, m);
        wr(A_SEC, s);
        wr(A_CTRL, cb);
        repeat (n * DIV - 1) @(negedge clk);
        wr(A_CTRL, cb | 8'h40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] v;
        rst = 1'b1;
        bus_addr = '0;
        bus_we = 1'b0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rdchk("R1 sec", A_SEC, 8'h00);
        rdchk("R1 min", A_MIN, 8'h00);
        rdchk("R1 hour", A_HOUR, 8'h00);
        rdchk("R1 wday", A_WDAY, 8'h00);
        rdchk("R1 ctrl", A_CTRL, 8'h01);
        rdchk("R1 flags", A_FLAG, 8'h00);
        chk("R13 irq reset", {6'b0, irq_alarm, irq_periodic}, 8'h00);

        // Vector table
        for (int i = 0; i < 8; i++) begin
            v = VECS[i];
            run_secs(v[63:56], v[55:48], v[47:40], v[39:32], int'(v[31:24]));
            rdchk(v[56] ? "R4 hour" : "R5 hour", A_HOUR, v[23:16]);
            rdchk("R3 min", A_MIN, v[15:8]);
            rdchk("R3 sec", A_SEC, v[7:0]);
        end

        // R2 exact edge of the first advance after a seconds write
        wr(A_CTRL, 8'h41);
        wr(A_SEC, 8'h20);
        wr(A_CTRL, 8'h01);
        repeat (DIV - 2) @(negedge clk);
        rdchk("R2 before tick", A_SEC, 8'h20);
        @(negedge clk);
        rdchk("R2 at tick", A_SEC, 8'h21);
        wr(A_CTRL, 8'h41);

        // R7 wait hold and single pending second
        wr(A_SEC, 8'h10);
        repeat (2 * DIV + 2) @(negedge clk);
        rdchk("R7 held", A_SEC, 8'h10);
        wr(A_CTRL, 8'h01);
        rdchk("R7 release edge", A_SEC, 8'h10);
        @(negedge clk);
        rdchk("R7 one pending", A_SEC, 8'h11);
        wr(A_CTRL, 8'h41);

        // R6 weekday
        wr(A_WDAY, 8'h06);
        run_secs(8'h01, 8'h23, 8'h59, 8'h59, 1);
        rdchk("R6 wrap 6 to 0", A_WDAY, 8'h00);
        wr(A_WDAY, 8'h04);
        run_secs(8'h01, 8'h10, 8'h59, 8'h59, 1);
        rdchk("R6 no change off midnight", A_WDAY, 8'h04);

        // R8 R10 alarm and minute event together
        wr(A_AMIN, 8'h00);
        wr(A_AHOUR, 8'h00);
        wr(A_AMASK, 8'h08);
        wr(A_WDAY, 8'h02);
        wr(A_FLAG, 8'h00);
        run_secs(8'h0F, 8'h23, 8'h59, 8'h59, 1);
        rdchk("R8 R10 both flags", A_FLAG, 8'h03);
        chk("R13 irq lines", {6'b0, irq_alarm, irq_periodic}, 8'h03);

        // R11 write semantics
        wr(A_FLAG, 8'h02);
        rdchk("R11 clear periodic only", A_FLAG, 8'h02);
        wr(A_FLAG, 8'h01);
        rdchk("R11 clear alarm only", A_FLAG, 8'h00);

        // R12 select frozen while enabled
        wr(A_CTRL, 8'h57);
        rdchk("R12 select ignored", A_CTRL, 8'h4F);

        // R8 weekday mask mismatch
        wr(A_WDAY, 8'h02);
        wr(A_AMASK, 8'h04);
        wr(A_FLAG, 8'h00);
        run_secs(8'h0F, 8'h23, 8'h59, 8'h59, 1);
        rdchk("R8 mask miss", A_FLAG, 8'h01);

        // R8 alarm disabled
        wr(A_WDAY, 8'h02);
        wr(A_AMASK, 8'h08);
        wr(A_FLAG, 8'h00);
        run_secs(8'h0D, 8'h23, 8'h59, 8'h59, 1);
        rdchk("R8 disabled", A_FLAG, 8'h01);

        // R9 illegal alarm hour for 24-hour mode never matches
        wr(A_AMASK, 8'h7F);
        wr(A_AMIN, 8'h59);
        wr(A_AHOUR, 8'h32);
        wr(A_FLAG, 8'h00);
        run_secs(8'h0F, 8'h32, 8'h58, 8'h59, 1);
        rdchk("R9 illegal hour", A_FLAG, 8'h01);

        // R5 R8 PM alarm in 12-hour mode
        wr(A_AMIN, 8'h00);
        wr(A_AHOUR, 8'h21);
        wr(A_FLAG, 8'h00);
        run_secs(8'h0E, 8'h32, 8'h59, 8'h59, 1);
        rdchk("R8 12-hour PM alarm", A_FLAG, 8'h03);

        // R11 clear on the same edge as the set
        wr(A_AHOUR, 8'h00);
        wr(A_FLAG, 8'h00);
        wr(A_CTRL, 8'h4F);
        wr(A_HOUR, 8'h23);
        wr(A_MIN, 8'h59);
        wr(A_SEC, 8'h59);
        wr(A_CTRL, 8'h0F);
        repeat (DIV - 2) @(negedge clk);
        wr(A_FLAG, 8'h00);
        wr(A_CTRL, 8'h4F);
        rdchk("R11 set beats clear", A_FLAG, 8'h03);

        // R10 per-second event after re-selecting with enable off
        wr(A_CTRL, 8'h41);
        wr(A_FLAG, 8'h00);
        run_secs(8'h05, 8'h10, 8'h00, 8'h00, 1);
        rdchk("R10 per-second", A_FLAG, 8'h01);
        rdchk("R12 select taken when disabled", A_CTRL, 8'h45);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule